// File: doc/BRIEF.md
# Regulator Fault Protection Supervisor

This block watches the protection comparators and the output-voltage reading of a multiphase voltage regulator and decides when the power stage must be shut off. It times how long each fault condition lasts and compares the digitised output voltage against the target code. When a fault is confirmed, it drops power-good and places the PWM drivers in their high-impedance state.

An overvoltage is handled in two steps. The supervisor first turns on an active pull-down until the output falls under the target, and only then tri-states the drivers. Every fault stays latched until the enable input is taken low or a power-on reset occurs. Enabling the block again starts with a one-cycle soft-start request, followed by a fixed soft-start interval before normal running resumes.

The PWM generator itself is outside this block. It takes `pwm_tristate` and `softstart_go` as commands.

Top module: `regfault_supervisor`

## Requirements
- R1: After reset (rst_n low at a clock edge) and while enable is low, pgood=0, pwm_tristate=1, pulldown_en=0 and softstart_go=0.
- R2: The first clock edge that samples enable high in the idle state starts soft-start. In the cycle that follows, softstart_go=1 and pwm_tristate=0. softstart_go is high for exactly one cycle per start.
- R3: Soft-start lasts SS_CYCLES cycles. After that, pgood=1 and pwm_tristate=0. pgood is high only in the running state.
- R4: An overcurrent flag high for OC_CYCLES consecutive sampled edges trips a fault. A run one edge shorter does not trip.
- R5: A phase-unbalance flag high for UNBAL_CYCLES consecutive edges trips a fault. Any low cycle restarts the count.
- R6: The way-overcurrent flag and the thermal flag each trip a fault on the first edge that samples them high.
- R7: Undervoltage is vout_code < target_code − UV_MARGIN. It trips a fault at once in the running state and is ignored during soft-start. A value exactly at the margin does not trip.
- R8: Overvoltage is vout_code > target_code + OV_MARGIN. It switches to pull-down at once: pulldown_en=1, pwm_tristate=0, pgood=0. A value exactly at the margin does not trip. Overvoltage wins when it coincides with another fault.
- R9: Pull-down continues while vout_code ≥ target_code. The first edge that samples vout_code < target_code ends it: pulldown_en=0 and pwm_tristate=1, with the fault latched.
- R10: A latched fault (pgood=0, pwm_tristate=1) persists whatever the fault inputs do, for as long as enable stays high.
- R11: enable low clears any state, including pull-down, back to idle on the next edge. Re-enabling then issues a new soft-start request.
- R12: Every fault source except undervoltage is also monitored during soft-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| enable | input | 1 | Regulator enable; low clears faults |
| oc_flag | input | 1 | Overcurrent comparator |
| unbal_flag | input | 1 | Phase-current unbalance comparator |
| woc_flag | input | 1 | Way-overcurrent comparator (1.5× limit) |
| therm_flag | input | 1 | Thermal shutdown comparator |
| vout_code | input | CODE_W | Digitised output voltage |
| target_code | input | CODE_W | Target voltage code |
| pgood | output | 1 | Power-good |
| pwm_tristate | output | 1 | Places PWM drivers in high impedance |
| pulldown_en | output | 1 | Active output pull-down |
| softstart_go | output | 1 | One-cycle soft-start request |

## Verification
The persistence timers are tested one cycle short of their limit and exactly at it. A timer that is off by one would trip early or late. The unbalance count is interrupted by a single low cycle to confirm that it restarts; a timer that only paused would trip too soon. The voltage limits are tested exactly at the margin and one code beyond it, so a comparison using the wrong inclusive or exclusive bound trips at the margin or misses the code past it. The overvoltage sequence is held at vout equal to target, where a design that ends pull-down too early would tri-state. Undervoltage during soft-start, overvoltage together with way-overcurrent, and enable dropped during pull-down each expose wrong masking, wrong priority, or a fault that survives its reset.

// File: rtl/regfault_pkg.sv
// Shared types for the regulator fault supervisor.
package regfault_pkg;
    typedef enum logic [2:0] {
        SUP_IDLE      = 3'd0,
        SUP_SOFTSTART = 3'd1,
        SUP_RUN       = 3'd2,
        SUP_OV_PD     = 3'd3,
        SUP_LATCHED   = 3'd4
    } sup_state_t;
endpackage

// File: rtl/fault_persist_timer.sv
// Persistence timer: counts consecutive armed cycles with cond high and
// flags trip on the HOLD_CYCLES-th such cycle. Any low cond or disarm
// restarts the count. Assumes HOLD_CYCLES >= 1.
module fault_persist_timer #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cond,
    output logic trip
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count the run length of cond, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!arm || !cond)
            cnt <= '0;
        else if (cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    // Trip once the run has reached the hold length.
    assign trip = arm && cond && (cnt == LIMIT);

    assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);
    assert_cnt_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (cnt == '0));
endmodule

// File: rtl/vout_window.sv
// Window comparator: classifies vout against target with separate
// under- and overvoltage margins, plus a below-target flag for ending
// the pull-down. Uses one extra bit so the sums cannot wrap.
module vout_window #(
    parameter int CODE_W    = 8,
    parameter int UV_MARGIN = 13,
    parameter int OV_MARGIN = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] vout_code,
    input  logic [CODE_W-1:0] target_code,
    output logic              uv,
    output logic              ov,
    output logic              below_target
);
    localparam int XW = CODE_W + 1;
    localparam logic [XW-1:0] UV_M = XW'(UV_MARGIN);
    localparam logic [XW-1:0] OV_M = XW'(OV_MARGIN);

    logic [XW-1:0] v_x, t_x;

    // Widen both codes and compare against the offset limits.
    always_comb begin
        v_x          = {1'b0, vout_code};
        t_x          = {1'b0, target_code};
        uv           = (v_x + UV_M) < t_x;
        ov           = v_x > (t_x + OV_M);
        below_target = v_x < t_x;
    end

    assert_window_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(uv && ov));
    assert_ov_not_below_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ov |-> !below_target);
endmodule

// File: rtl/regfault_supervisor.sv
// Fault supervisor for a multiphase regulator. It times the overcurrent
// and unbalance flags, takes way-overcurrent, thermal and voltage-window
// faults at once, sequences pull-down before tri-state on overvoltage,
// and latches faults until enable drops or reset. Assumes the flags are
// already synchronous to clk.
module regfault_supervisor #(
    parameter int CODE_W       = 8,
    parameter int UV_MARGIN    = 13,
    parameter int OV_MARGIN    = 13,
    parameter int OC_CYCLES    = 1188,
    parameter int UNBAL_CYCLES = 125000,
    parameter int SS_CYCLES    = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              oc_flag,
    input  logic              unbal_flag,
    input  logic              woc_flag,
    input  logic              therm_flag,
    input  logic [CODE_W-1:0] vout_code,
    input  logic [CODE_W-1:0] target_code,
    output logic              pgood,
    output logic              pwm_tristate,
    output logic              pulldown_en,
    output logic              softstart_go
);
    import regfault_pkg::*;

    sup_state_t state, state_nx;
    logic monitor, oc_trip, unbal_trip, ss_done;
    logic uv, ov, below_target, hard_fault;

    // Timers run only while the supervisor is watching the output.
    assign monitor = (state == SUP_SOFTSTART) || (state == SUP_RUN);

    fault_persist_timer #(.HOLD_CYCLES(OC_CYCLES)) u_oc_timer (
        .clk(clk), .rst_n(rst_n), .arm(monitor), .cond(oc_flag), .trip(oc_trip));

    fault_persist_timer #(.HOLD_CYCLES(UNBAL_CYCLES)) u_unbal_timer (
        .clk(clk), .rst_n(rst_n), .arm(monitor), .cond(unbal_flag), .trip(unbal_trip));

    fault_persist_timer #(.HOLD_CYCLES(SS_CYCLES)) u_ss_timer (
        .clk(clk), .rst_n(rst_n), .arm(state == SUP_SOFTSTART), .cond(1'b1),
        .trip(ss_done));

    vout_window #(.CODE_W(CODE_W), .UV_MARGIN(UV_MARGIN), .OV_MARGIN(OV_MARGIN)) u_window (
        .clk(clk), .rst_n(rst_n), .vout_code(vout_code), .target_code(target_code),
        .uv(uv), .ov(ov), .below_target(below_target));

    // Collect the faults that go straight to the latched state.
    assign hard_fault = woc_flag || therm_flag || oc_trip || unbal_trip
                     || (uv && (state == SUP_RUN));

    // Next-state selection; enable low overrides everything.
    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = SUP_IDLE;
        end else begin
            unique case (state)
                SUP_IDLE:      state_nx = SUP_SOFTSTART;
                SUP_SOFTSTART: if (ov) state_nx = SUP_OV_PD;
                               else if (hard_fault) state_nx = SUP_LATCHED;
                               else if (ss_done) state_nx = SUP_RUN;
                SUP_RUN:       if (ov) state_nx = SUP_OV_PD;
                               else if (hard_fault) state_nx = SUP_LATCHED;
                SUP_OV_PD:     if (below_target) state_nx = SUP_LATCHED;
                SUP_LATCHED:   state_nx = SUP_LATCHED;
                default:       state_nx = SUP_IDLE;
            endcase
        end
    end

    // State register with power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SUP_IDLE;
        else        state <= state_nx;
    end

    // One-cycle soft-start request on leaving idle.
    always_ff @(posedge clk) begin
        if (!rst_n) softstart_go <= 1'b0;
        else        softstart_go <= (state == SUP_IDLE) && (state_nx == SUP_SOFTSTART);
    end

    // Output decode from the state.
    assign pgood        = (state == SUP_RUN);
    assign pwm_tristate = (state == SUP_IDLE) || (state == SUP_LATCHED);
    assign pulldown_en  = (state == SUP_OV_PD);

    assert_pgood_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> $past(enable));
    assert_go_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        softstart_go |=> !softstart_go);
    assert_latch_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SUP_LATCHED && enable) |=> (state == SUP_LATCHED));
    assert_pd_ends_tristate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulldown_en) && $past(enable)) |-> pwm_tristate);
    assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pwm_tristate && !pgood && !pulldown_en));
endmodule

// File: tb/regfault_supervisor_test.sv
module regfault_supervisor_test;
    localparam int W = 8, OCN = 10, UBN = 40, SSN = 5;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
    logic oc_flag = 1'b0, unbal_flag = 1'b0, woc_flag = 1'b0, therm_flag = 1'b0;
    logic [W-1:0] vout_code = 8'd100, target_code = 8'd100;
    logic pgood, pwm_tristate, pulldown_en, softstart_go;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    regfault_supervisor #(.CODE_W(W), .UV_MARGIN(13), .OV_MARGIN(13),
        .OC_CYCLES(OCN), .UNBAL_CYCLES(UBN), .SS_CYCLES(SSN)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .oc_flag(oc_flag),
        .unbal_flag(unbal_flag), .woc_flag(woc_flag), .therm_flag(therm_flag),
        .vout_code(vout_code), .target_code(target_code), .pgood(pgood),
        .pwm_tristate(pwm_tristate), .pulldown_en(pulldown_en),
        .softstart_go(softstart_go));

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Compare {pgood, pwm_tristate, pulldown_en, softstart_go}.
    task automatic expect_out(string tag, logic [3:0] exp);
        logic [3:0] act;
        act = {pgood, pwm_tristate, pulldown_en, softstart_go};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: outputs actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic quiet();
        oc_flag = 0; unbal_flag = 0; woc_flag = 0; therm_flag = 0;
        vout_code = 8'd100; target_code = 8'd100;
    endtask

    task automatic shutdown();
        enable = 0; quiet(); tick(1);
        expect_out("R11 idle after enable low", 4'b0100);
    endtask

    task automatic bring_up();
        enable = 1; tick(1);
        expect_out("R2 soft-start request", 4'b0001);
        tick(SSN - 1);
        expect_out("R3 still in soft-start", 4'b0000);
        tick(1);
        expect_out("R3 running", 4'b1000);
    endtask

    task automatic t_reset();
        rst_n = 0; enable = 1; tick(3);
        rst_n = 1; enable = 0; tick(1);
        expect_out("R1 reset state", 4'b0100);
        tick(2);
        expect_out("R1 idle while disabled", 4'b0100);
    endtask

    task automatic t_uv_softstart();
        vout_code = 8'd0; enable = 1; tick(1);
        expect_out("R7 UV ignored in soft-start", 4'b0001);
        tick(SSN);
        expect_out("R7 reaches run despite UV", 4'b1000);
        tick(1);
        expect_out("R7 UV trips in run", 4'b0100);
        vout_code = 8'd100; tick(3);
        expect_out("R10 latch persists", 4'b0100);
        shutdown();
    endtask

    task automatic t_oc();
        bring_up();
        oc_flag = 1; tick(OCN - 1); oc_flag = 0; tick(1);
        expect_out("R4 short overcurrent no trip", 4'b1000);
        oc_flag = 1; tick(OCN - 1);
        expect_out("R4 one short of limit", 4'b1000);
        tick(1);
        expect_out("R4 overcurrent trip", 4'b0100);
        oc_flag = 0; tick(2);
        expect_out("R10 latched after flag clears", 4'b0100);
        shutdown();
    endtask

    task automatic t_unbal();
        bring_up();
        unbal_flag = 1; tick(UBN - 1); unbal_flag = 0; tick(1);
        unbal_flag = 1; tick(UBN - 1);
        expect_out("R5 interrupted run restarts", 4'b1000);
        tick(1);
        expect_out("R5 unbalance trip", 4'b0100);
        shutdown();
    endtask

    task automatic t_immediate();
        bring_up();
        woc_flag = 1; tick(1);
        expect_out("R6 way-overcurrent immediate", 4'b0100);
        shutdown();
        bring_up();
        therm_flag = 1; tick(1);
        expect_out("R6 thermal immediate", 4'b0100);
        shutdown();
    endtask

    task automatic t_uv_edge();
        bring_up();
        vout_code = 8'd87; tick(2);
        expect_out("R7 UV at margin no trip", 4'b1000);
        vout_code = 8'd86; tick(1);
        expect_out("R7 UV beyond margin trips", 4'b0100);
        shutdown();
    endtask

    task automatic t_ov();
        bring_up();
        vout_code = 8'd113; tick(2);
        expect_out("R8 OV at margin no trip", 4'b1000);
        vout_code = 8'd114; tick(1);
        expect_out("R8 pull-down starts", 4'b0010);
        vout_code = 8'd100; tick(2);
        expect_out("R9 pull-down holds at target", 4'b0010);
        vout_code = 8'd99; tick(1);
        expect_out("R9 tri-state after below target", 4'b0100);
        tick(2);
        expect_out("R10 OV fault latched", 4'b0100);
        shutdown();
    endtask

    task automatic t_ov_priority_abort();
        bring_up();
        vout_code = 8'd200; woc_flag = 1; tick(1);
        expect_out("R8 OV wins over way-overcurrent", 4'b0010);
        enable = 0; tick(1);
        expect_out("R11 enable low aborts pull-down", 4'b0100);
        quiet(); tick(1);
        bring_up();
        shutdown();
    endtask

    task automatic t_softstart_fault();
        enable = 1; tick(1);
        expect_out("R12 soft-start entered", 4'b0001);
        therm_flag = 1; tick(1);
        expect_out("R12 thermal in soft-start", 4'b0100);
        therm_flag = 0; tick(SSN + 2);
        expect_out("R12 stays latched", 4'b0100);
        shutdown();
    endtask

    initial begin
        t_reset();
        t_uv_softstart();
        t_oc();
        t_unbal();
        t_immediate();
        t_uv_edge();
        t_ov();
        t_ov_priority_abort();
        t_softstart_fault();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule